// File: doc/BRIEF.md
# Buffered Host-to-Link Byte Bridge

This block joins a byte-wide host I/O bus to a byte-serial link adapter that moves one byte at a time with a valid/acknowledge handshake in each direction. Two byte queues sit between the two sides. The inbound queue collects bytes arriving from the adapter. The outbound queue holds bytes the host has written. The bridge answers the adapter's handshakes by itself, so a host access never waits on the link. The host sees the fill state of both queues in a status register and can enable level-sensitive interrupts on them.

Two eight-byte register windows are decoded. The buffered window reaches the queues, the status register and the control register. The direct window is a plain polled interface to the adapter, one byte at a time. The direct window is only active while direct mode is set, and in that mode the queue engines on the link side stand still. A control bit swaps the base addresses of the two windows.

Two small state machines run the link side. The outbound machine has the states OUT_IDLE and OUT_BUSY. OUT_IDLE goes to OUT_BUSY when it loads a byte, which comes from the outbound queue or, in direct mode, from a direct write. OUT_BUSY goes back to OUT_IDLE on the adapter acknowledge. The inbound machine has the states IN_WAIT and IN_ACK. IN_WAIT goes to IN_ACK when it takes an offered byte and there is room for it. IN_ACK always returns to IN_WAIT after one cycle.

Top module: `link_host_bridge`

## Requirements
- R1: After reset, buffered status reads 0x09, control reads 0x00, irq is low, and neither lnk_out_valid nor lnk_in_ack is asserted.
- R2: Bytes offered on the inbound link are acknowledged with a one-cycle lnk_in_ack pulse. The host reads them from the buffered data register (offset 0) in arrival order.
- R3: A buffered data read while the inbound queue is empty returns 0x00 and consumes nothing; the next byte to arrive is the next byte read.
- R4: While the inbound queue holds DEPTH bytes, an offered byte is not acknowledged. It is taken once a host read frees a slot.
- R5: Bytes written to the buffered data register leave on the outbound link in write order. lnk_out_valid stays high and lnk_out_data stays stable until lnk_out_ack.
- R6: A buffered data write while the outbound queue is full is dropped and sets a sticky overflow flag, status bit 6. A read of buffered status clears the flag.
- R7: Buffered status (offset 1) has these bits: bit0 inbound empty, bit1 inbound at least DEPTH/2, bit2 inbound full, bit3 outbound empty, bit4 outbound at least DEPTH/2, bit5 outbound full.
- R8: irq is a level output. It is high while (control bit0 and inbound at least half) or (control bit1 and outbound full).
- R9: The buffered window is based at 0x150 and the direct window at 0x158, with control at buffered offset 2. Setting control bit2 swaps the two bases.
- R10: With control bit3 set (direct mode), the queue engines on the link side pause. An inbound byte is held in a one-byte register. A direct data read (offset 0) returns that byte, or 0x00 if none is held. A direct data write is sent straight to the link. Direct status (offset 1) reports bit0 for a byte held and bit1 for the transmitter busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from address |
| lnk_in_valid | input | 1 | Adapter offers an inbound byte |
| lnk_in_data | input | 8 | Inbound byte |
| lnk_in_ack | output | 1 | Bridge took the inbound byte |
| lnk_out_valid | output | 1 | Bridge offers an outbound byte |
| lnk_out_data | output | 8 | Outbound byte |
| lnk_out_ack | input | 1 | Adapter took the outbound byte |
| irq | output | 1 | Level interrupt request |

## Verification
A pointer or count that drifts in either queue shows at the ports within one host access. It appears as a byte out of order, a 0x00 where data was due, or a status bit that disagrees with the number of bytes pushed. A stuck state machine shows on the link pins within a few cycles: a missing or doubled acknowledge pulse, or valid dropping before acknowledge. A decode error shows at once, because the wrong register answers a read at a known address.

// File: rtl/lhb_pkg.sv
package lhb_pkg;
    typedef enum logic {OUT_IDLE, OUT_BUSY} out_state_t;
    typedef enum logic {IN_WAIT, IN_ACK} in_state_t;

    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CTRL = 3'd2;

    localparam int CTRL_IE_IN  = 0;
    localparam int CTRL_IE_OUT = 1;
    localparam int CTRL_SWAP   = 2;
    localparam int CTRL_DIRECT = 3;
endpackage

// File: rtl/lhb_fifo.sv
module lhb_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          half,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign half    = (count >= CW'(DEPTH / 2));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/lhb_out_fsm.sv
module lhb_out_fsm
    import lhb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       direct_en,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    input  logic       dir_wr,
    input  logic [7:0] dir_data,
    input  logic       link_ack,
    output logic       q_pop,
    output logic       link_valid,
    output logic [7:0] link_data,
    output logic       busy
);
    out_state_t state, state_nx;
    logic       load;
    logic [7:0] load_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= OUT_IDLE;
            link_data <= '0;
        end else begin
            state <= state_nx;
            if (load) link_data <= load_byte;
        end
    end

    always_comb begin
        state_nx  = state;
        load      = 1'b0;
        q_pop     = 1'b0;
        load_byte = q_data;
        unique case (state)
            OUT_IDLE: begin
                if (direct_en) begin
                    if (dir_wr) begin
                        load      = 1'b1;
                        load_byte = dir_data;
                        state_nx  = OUT_BUSY;
                    end
                end else if (!q_empty) begin
                    load     = 1'b1;
                    q_pop    = 1'b1;
                    state_nx = OUT_BUSY;
                end
            end
            OUT_BUSY: if (link_ack) state_nx = OUT_IDLE;
        endcase
    end

    assign link_valid = (state == OUT_BUSY);
    assign busy       = (state == OUT_BUSY);
endmodule

// File: rtl/lhb_in_fsm.sv
module lhb_in_fsm
    import lhb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic direct_en,
    input  logic link_valid,
    input  logic q_full,
    input  logic dir_full,
    output logic q_push,
    output logic dir_load,
    output logic link_ack
);
    in_state_t state, state_nx;
    logic      take;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IN_WAIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            IN_WAIT: begin
                take = link_valid && (direct_en ? !dir_full : !q_full);
                if (take) state_nx = IN_ACK;
            end
            IN_ACK: state_nx = IN_WAIT;
        endcase
    end

    assign q_push   = take && !direct_en;
    assign dir_load = take && direct_en;
    assign link_ack = (state == IN_ACK);
endmodule

// File: rtl/link_host_bridge.sv
module link_host_bridge
    import lhb_pkg::*;
#(
    parameter int                DEPTH     = 1024,
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] FAST_BASE = 10'h150,
    parameter logic [ADDR_W-1:0] SLOW_BASE = 10'h158,
    localparam int               CW        = $clog2(DEPTH) + 1,
    localparam int               WIN_LSB   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              lnk_in_valid,
    input  logic [7:0]        lnk_in_data,
    output logic              lnk_in_ack,
    output logic              lnk_out_valid,
    output logic [7:0]        lnk_out_data,
    input  logic              lnk_out_ack,
    output logic              irq
);
    logic [3:0]        ctrl_q;
    logic              ovf_q, ovf_set;
    logic              direct_en;
    logic [ADDR_W-1:0] fast_base, slow_base;
    logic              fast_hit, slow_hit;
    logic [2:0]        off;
    logic              f_data_rd, f_data_wr, f_stat_rd, f_ctrl_wr;
    logic              s_data_rd, s_data_wr;

    logic [CW-1:0] in_count, out_count;
    logic          in_empty, in_half, in_full;
    logic          out_empty, out_half, out_full;
    logic [7:0]    in_rdata, out_qdata;
    logic          in_push, out_pop;
    logic          dir_load, dir_full;
    logic [7:0]    dir_byte;
    logic          out_busy;

    assign direct_en = ctrl_q[CTRL_DIRECT];
    assign fast_base = ctrl_q[CTRL_SWAP] ? SLOW_BASE : FAST_BASE;
    assign slow_base = ctrl_q[CTRL_SWAP] ? FAST_BASE : SLOW_BASE;
    assign fast_hit  = host_addr[ADDR_W-1:WIN_LSB] == fast_base[ADDR_W-1:WIN_LSB];
    assign slow_hit  = host_addr[ADDR_W-1:WIN_LSB] == slow_base[ADDR_W-1:WIN_LSB];
    assign off       = host_addr[WIN_LSB-1:0];

    assign f_data_rd = host_rd && fast_hit && off == OFF_DATA;
    assign f_data_wr = host_wr && fast_hit && off == OFF_DATA;
    assign f_stat_rd = host_rd && fast_hit && off == OFF_STAT;
    assign f_ctrl_wr = host_wr && fast_hit && off == OFF_CTRL;
    assign s_data_rd = host_rd && slow_hit && off == OFF_DATA && direct_en;
    assign s_data_wr = host_wr && slow_hit && off == OFF_DATA && direct_en;
    assign ovf_set   = f_data_wr && out_full;

    lhb_fifo #(.DEPTH(DEPTH), .W(8)) u_in_q (
        .clk(clk), .rst_n(rst_n), .push(in_push), .wdata(lnk_in_data),
        .pop(f_data_rd), .rdata(in_rdata), .count(in_count),
        .empty(in_empty), .half(in_half), .full(in_full)
    );

    lhb_fifo #(.DEPTH(DEPTH), .W(8)) u_out_q (
        .clk(clk), .rst_n(rst_n), .push(f_data_wr), .wdata(host_wdata),
        .pop(out_pop), .rdata(out_qdata), .count(out_count),
        .empty(out_empty), .half(out_half), .full(out_full)
    );

    lhb_in_fsm u_in_fsm (
        .clk(clk), .rst_n(rst_n), .direct_en(direct_en),
        .link_valid(lnk_in_valid), .q_full(in_full), .dir_full(dir_full),
        .q_push(in_push), .dir_load(dir_load), .link_ack(lnk_in_ack)
    );

    lhb_out_fsm u_out_fsm (
        .clk(clk), .rst_n(rst_n), .direct_en(direct_en),
        .q_empty(out_empty), .q_data(out_qdata),
        .dir_wr(s_data_wr), .dir_data(host_wdata), .link_ack(lnk_out_ack),
        .q_pop(out_pop), .link_valid(lnk_out_valid), .link_data(lnk_out_data),
        .busy(out_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ovf_q    <= 1'b0;
            dir_full <= 1'b0;
            dir_byte <= '0;
        end else begin
            if (f_ctrl_wr) ctrl_q <= host_wdata[3:0];
            if (ovf_set)        ovf_q <= 1'b1;
            else if (f_stat_rd) ovf_q <= 1'b0;
            if (dir_load) begin
                dir_full <= 1'b1;
                dir_byte <= lnk_in_data;
            end else if (s_data_rd) begin
                dir_full <= 1'b0;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (fast_hit) begin
            unique case (off)
                OFF_DATA: host_rdata = in_empty ? 8'h00 : in_rdata;
                OFF_STAT: host_rdata = {1'b0, ovf_q, out_full, out_half, out_empty,
                                        in_full, in_half, in_empty};
                OFF_CTRL: host_rdata = {4'b0, ctrl_q};
                default:  host_rdata = '0;
            endcase
        end else if (slow_hit) begin
            unique case (off)
                OFF_DATA: host_rdata = (direct_en && dir_full) ? dir_byte : 8'h00;
                OFF_STAT: host_rdata = {6'b0, out_busy, dir_full};
                default:  host_rdata = '0;
            endcase
        end
    end

    assign irq = (ctrl_q[CTRL_IE_IN] && in_half) || (ctrl_q[CTRL_IE_OUT] && out_full);
endmodule

// File: rtl/lhb_checker.sv
module lhb_checker #(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ack,
    input logic          out_valid,
    input logic          out_ack,
    input logic [7:0]    out_data,
    input logic [CW-1:0] in_count,
    input logic [CW-1:0] out_count,
    input logic          ovf,
    input logic          ovf_set,
    input logic          stat_rd,
    input logic          direct_en,
    input logic          out_push
);
    assert_in_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ack |=> !in_ack);

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));

    assert_in_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_count <= CW'(DEPTH));

    assert_out_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= CW'(DEPTH));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !stat_rd) |=> ovf);

    assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovf_set) |=> !ovf);

    assert_direct_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        direct_en |=> (out_count >= $past(out_count)));

    assert_push_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_en && out_push && out_count < CW'(DEPTH)) |=> (out_count == $past(out_count) + 1'b1));
endmodule

bind link_host_bridge lhb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ack(lnk_in_ack), .out_valid(lnk_out_valid),
    .out_ack(lnk_out_ack), .out_data(lnk_out_data), .in_count(in_count),
    .out_count(out_count), .ovf(ovf_q), .ovf_set(ovf_set), .stat_rd(f_stat_rd),
    .direct_en(direct_en), .out_push(f_data_wr)
);

// File: tb/link_host_bridge_tb.sv
module link_host_bridge_tb;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       lnk_in_valid = 1'b0;
    logic [7:0] lnk_in_data = '0;
    logic       lnk_in_ack;
    logic       lnk_out_valid;
    logic [7:0] lnk_out_data;
    logic       lnk_out_ack = 1'b0;
    logic       irq;

    int checks = 0, errors = 0, received = 0;
    logic sink_en = 1'b0;
    logic [7:0] out_q[$];
    logic [7:0] in_q[$];

    always #4 clk = ~clk;

    link_host_bridge #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .lnk_in_valid(lnk_in_valid), .lnk_in_data(lnk_in_data), .lnk_in_ack(lnk_in_ack),
        .lnk_out_valid(lnk_out_valid), .lnk_out_data(lnk_out_data),
        .lnk_out_ack(lnk_out_ack), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // monitor: link sink, compares outbound bytes with the scoreboard
    always @(negedge clk) begin
        if (sink_en && lnk_out_valid && !lnk_out_ack) begin
            received++;
            checks++;
            if (out_q.size() == 0) begin
                errors++;
                $display("FAIL R5 actual=%02h expected=none", lnk_out_data);
            end else begin
                logic [7:0] e;
                e = out_q.pop_front();
                if (lnk_out_data !== e) begin
                    errors++;
                    $display("FAIL R5 actual=%02h expected=%02h", lnk_out_data, e);
                end
            end
            lnk_out_ack <= 1'b1;
        end else begin
            lnk_out_ack <= 1'b0;
        end
    end

    task automatic host_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic fifo_write(input logic [7:0] d);
        out_q.push_back(d);
        host_write(10'h150, d);
    endtask

    task automatic link_send(input logic [7:0] d, input logic to_fifo);
        int n = 0;
        @(negedge clk);
        lnk_in_valid = 1'b1; lnk_in_data = d;
        while (!lnk_in_ack && n < 50) begin
            @(negedge clk);
            n++;
        end
        lnk_in_valid = 1'b0;
        checks++;
        if (!lnk_in_ack) begin
            errors++;
            $display("FAIL R2 actual=noack expected=ack");
        end else if (to_fifo) begin
            in_q.push_back(d);
        end
    endtask

    task automatic read_expect(input string req);
        logic [7:0] d, e;
        e = (in_q.size() != 0) ? in_q.pop_front() : 8'h00;
        host_read(10'h150, d);
        check(req, d, e);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_read(10'h151, d); check("R1 status", d, 8'h09);
        host_read(10'h152, d); check("R1 control", d, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 link pins", {6'b0, lnk_out_valid, lnk_in_ack}, 8'h00);

        // R2 ordering
        link_send(8'h11, 1'b1); link_send(8'h22, 1'b1); link_send(8'h33, 1'b1);
        repeat (3) read_expect("R2 order");

        // R3 empty read
        host_read(10'h150, d); check("R3 empty read", d, 8'h00);
        link_send(8'hA5, 1'b1);
        read_expect("R3 next after empty");

        // R7 / R8 half and full of inbound queue
        for (int i = 0; i < DEPTH / 2; i++) link_send(8'h40 + 8'(i), 1'b1);
        host_read(10'h151, d); check("R7 inbound half", d, 8'h0A);
        check("R8 irq masked", {7'b0, irq}, 8'h00);
        host_write(10'h152, 8'h01);
        #1 check("R8 irq in-half", {7'b0, irq}, 8'h01);
        for (int i = 0; i < DEPTH / 2; i++) link_send(8'h60 + 8'(i), 1'b1);
        host_read(10'h151, d); check("R7 inbound full", d, 8'h0E);

        // R4 no ack while full
        @(negedge clk);
        lnk_in_valid = 1'b1; lnk_in_data = 8'h77;
        n = 0;
        repeat (6) begin @(negedge clk); if (lnk_in_ack) n++; end
        check("R4 stall", 8'(n), 8'h00);
        read_expect("R4 read frees slot");
        n = 0;
        while (!lnk_in_ack && n < 20) begin @(negedge clk); n++; end
        check("R4 taken", {7'b0, lnk_in_ack}, 8'h01);
        lnk_in_valid = 1'b0;
        in_q.push_back(8'h77);
        repeat (DEPTH) read_expect("R4 drain order");
        #1 check("R8 irq drops", {7'b0, irq}, 8'h00);
        host_write(10'h152, 8'h02);

        // R5 / R6 outbound path and overflow
        for (int i = 0; i < DEPTH + 1; i++) fifo_write(8'h80 + 8'(i));
        host_write(10'h150, 8'hEE);
        #1 check("R8 irq out-full", {7'b0, irq}, 8'h01);
        host_read(10'h151, d); check("R6 overflow set", d, 8'h71);
        host_read(10'h151, d); check("R6 overflow cleared", d, 8'h31);
        host_write(10'h152, 8'h00);
        sink_en = 1'b1;
        repeat (60) @(negedge clk);
        check("R5 bytes sent", 8'(received), 8'(DEPTH + 1));
        check("R6 dropped byte absent", 8'(out_q.size()), 8'h00);
        host_read(10'h151, d); check("R7 drained", d, 8'h09);

        // R9 window swap
        host_write(10'h152, 8'h04);
        host_read(10'h159, d); check("R9 swapped buffered status", d, 8'h09);
        host_read(10'h151, d); check("R9 swapped direct status", d, 8'h00);
        host_read(10'h15A, d); check("R9 control at new base", d, 8'h04);
        host_write(10'h15A, 8'h00);
        host_read(10'h152, d); check("R9 restored", d, 8'h00);

        // R10 direct mode
        host_write(10'h152, 8'h08);
        n = received;
        host_write(10'h150, 8'h3C);
        repeat (10) @(negedge clk);
        check("R10 queue paused", 8'(received - n), 8'h00);
        host_read(10'h151, d); check("R10 queue held", d, 8'h01);
        link_send(8'h5A, 1'b0);
        host_read(10'h159, d); check("R10 direct status held", d, 8'h01);
        host_read(10'h158, d); check("R10 direct read", d, 8'h5A);
        host_read(10'h158, d); check("R10 direct read empty", d, 8'h00);
        out_q.push_back(8'hC3);
        host_write(10'h158, 8'hC3);
        repeat (10) @(negedge clk);
        check("R10 direct write sent", 8'(received - n), 8'h01);
        out_q.push_back(8'h3C);
        host_write(10'h152, 8'h00);
        repeat (10) @(negedge clk);
        check("R10 queue resumes", 8'(out_q.size()), 8'h00);
        host_read(10'h158, d); check("R10 direct off reads zero", d, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule